// File: doc/BRIEF.md
# Bulk command stream register decoder

This block sits behind a byte-wide command channel and turns a stream of bulk messages into register updates for a display path. It takes one byte per cycle when `in_valid` is high. Each message opens with the header byte 0xAF, and a command code follows the header. Two command codes are understood. Code 0x20 is a four-byte register write: header, code, register address, data. Code 0x6A is a nine-byte copy request. The block does not act on a copy request; it only presents its source address, pixel count and destination address as one pulse on a request port.

Register writes never reach the display path directly. Each write lands in a shadow copy of the register file. The whole shadow set moves into the active set in a single cycle, and only when the video lock register at address 0xFF receives the unlock value 0xFF. The lock value 0x00 marks the start of a batch. The active set is exported as a flat vector. Three decoded views are also exported: the two 24-bit frame base addresses and the 16-bit pixel clock divider.

Top module: `bulk_cmd_decoder`

## Requirements
- R1: After reset the active register vector is all zero, `locked` is 0 and `copy_valid` is 0.
- R2: The byte sequence 0xAF, 0x20, A, D with A below NREGS (48) stores D in shadow register A. The active vector does not change because of it, whether or not the lock is held.
- R3: A write of 0xFF to address 0xFF copies every shadow register into the active set. The new values are visible in the cycle after the data byte is accepted.
- R4: A write of 0x00 to address 0xFF sets `locked`, and the unlock write clears it. Any other data byte written to 0xFF changes neither `locked` nor the active vector.
- R5: `base16` is {reg 0x20, reg 0x21, reg 0x22} and `base8` is {reg 0x26, reg 0x27, reg 0x28}, high byte first in both. `pclk_div` is {reg 0x1C, reg 0x1B}, with the low byte at the lower address. All three are taken from the active set.
- R6: The sequence 0xAF, 0x6A, S2, S1, S0, N, D2, D1, D0 raises `copy_valid` for exactly one cycle, the cycle after D0 is accepted. In that cycle `copy_src` = {S2,S1,S0}, `copy_count` = N and `copy_dst` = {D2,D1,D0}.
- R7: A header byte followed by another header byte, or by the end of the stream, has no effect. A message that follows it parses normally.
- R8: After a header, any command code other than 0x20 or 0x6A makes the parser discard bytes up to the next 0xAF. That 0xAF opens a new message.
- R9: Bytes other than 0xAF that arrive between messages are discarded.
- R10: A write to an address of NREGS or above, other than 0xFF, changes no register.
- R11: `in_ready` is always 1, and a byte is taken only in a cycle where `in_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Byte present on `in_data` |
| in_data | input | 8 | Stream byte |
| in_ready | output | 1 | Byte accepted (always 1) |
| locked | output | 1 | Video register lock held |
| act_regs | output | NREGS*8 | Active register set, register i at bits [8i+7:8i] |
| base16 | output | 24 | Active 16bpp frame base address |
| base8 | output | 24 | Active 8bpp frame base address |
| pclk_div | output | 16 | Active pixel clock divider |
| copy_valid | output | 1 | One-cycle copy request strobe |
| copy_src | output | 24 | Copy source address |
| copy_count | output | 8 | Copy pixel count |
| copy_dst | output | 24 | Copy destination address |

## Verification
Two actions can fall in the same cycle. One is the commit of the shadow set into the active set. The other is the acceptance of the first byte of the next message. The bench makes this happen by driving an unlock write and then a copy message with no idle cycle between them. It then judges the result two ways: the active vector must match the model's shadow image, and the copy request must come out with the expected fields. In the same way, the cycle that presents a copy pulse also accepts the header of the following write, and the scoreboard confirms that this write still lands in the register file.

// File: rtl/bulk_cmd_pkg.sv
package bulk_cmd_pkg;
  localparam logic [7:0] HDR_BYTE    = 8'hAF;
  localparam logic [7:0] CMD_WREG    = 8'h20;
  localparam logic [7:0] CMD_COPY    = 8'h6A;
  localparam logic [7:0] LOCK_ADDR   = 8'hFF;
  localparam logic [7:0] LOCK_VAL    = 8'h00;
  localparam logic [7:0] UNLOCK_VAL  = 8'hFF;
  localparam int         COPY_BYTES  = 7;
  localparam int         B16_HI      = 'h20;
  localparam int         B8_HI       = 'h26;
  localparam int         PCLK_LO     = 'h1B;

  typedef enum logic [2:0] {
    P_IDLE, P_HDR, P_ADDR, P_DATA, P_COPY, P_SKIP
  } pstate_t;

  function automatic logic [23:0] copy_src_of(input logic [55:0] sh);
    return sh[55:32];
  endfunction
  function automatic logic [7:0] copy_cnt_of(input logic [55:0] sh);
    return sh[31:24];
  endfunction
  function automatic logic [23:0] copy_dst_of(input logic [55:0] sh);
    return sh[23:0];
  endfunction
  function automatic logic [7:0] reg_of(input logic [511:0] v, input int i);
    return v[i*8 +: 8];
  endfunction
endpackage

// File: rtl/bulk_cmd_parser.sv
module bulk_cmd_parser
  import bulk_cmd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [7:0]  in_data,
  output logic        wr_fire,
  output logic [7:0]  wr_addr,
  output logic [7:0]  wr_data,
  output logic        copy_valid,
  output logic [23:0] copy_src,
  output logic [7:0]  copy_count,
  output logic [23:0] copy_dst
);
  localparam int CW = $clog2(COPY_BYTES + 1);

  pstate_t       st_q;
  logic [7:0]    addr_q;
  logic [CW-1:0] cnt_q;
  logic [55:0]   sh_q;
  logic          cv_q;
  logic          last_copy;

  assign last_copy = in_valid && (st_q == P_COPY) && (cnt_q == CW'(COPY_BYTES - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= P_IDLE;
      addr_q <= '0;
      cnt_q  <= '0;
      sh_q   <= '0;
      cv_q   <= 1'b0;
    end else begin
      cv_q <= last_copy;
      if (in_valid) begin
        unique case (st_q)
          P_IDLE: if (in_data == HDR_BYTE) st_q <= P_HDR;
          P_HDR: begin
            if (in_data == HDR_BYTE)      st_q <= P_HDR;
            else if (in_data == CMD_WREG) st_q <= P_ADDR;
            else if (in_data == CMD_COPY) begin
              st_q  <= P_COPY;
              cnt_q <= '0;
            end else                      st_q <= P_SKIP;
          end
          P_ADDR: begin
            addr_q <= in_data;
            st_q   <= P_DATA;
          end
          P_DATA: st_q <= P_IDLE;
          P_COPY: begin
            sh_q  <= {sh_q[47:0], in_data};
            cnt_q <= cnt_q + 1'b1;
            if (last_copy) st_q <= P_IDLE;
          end
          P_SKIP: if (in_data == HDR_BYTE) st_q <= P_HDR;
          default: st_q <= P_IDLE;
        endcase
      end
    end
  end

  assign wr_fire    = in_valid && (st_q == P_DATA);
  assign wr_addr    = addr_q;
  assign wr_data    = in_data;
  assign copy_valid = cv_q;
  assign copy_src   = copy_src_of(sh_q);
  assign copy_count = copy_cnt_of(sh_q);
  assign copy_dst   = copy_dst_of(sh_q);
endmodule

// File: rtl/bulk_cmd_lockctl.sv
module bulk_cmd_lockctl
  import bulk_cmd_pkg::*;
#(
  parameter int NREGS = 48
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_fire,
  input  logic [7:0] wr_addr,
  input  logic [7:0] wr_data,
  output logic       store_en,
  output logic       commit_fire,
  output logic       locked
);
  logic lock_hit;
  logic locked_q;

  assign lock_hit    = wr_fire && (wr_addr == LOCK_ADDR);
  assign commit_fire = lock_hit && (wr_data == UNLOCK_VAL);
  assign store_en    = wr_fire && (int'(wr_addr) < NREGS);

  always_ff @(posedge clk) begin
    if (!rst_n)                                 locked_q <= 1'b0;
    else if (commit_fire)                       locked_q <= 1'b0;
    else if (lock_hit && wr_data == LOCK_VAL)   locked_q <= 1'b1;
  end

  assign locked = locked_q;
endmodule

// File: rtl/bulk_cmd_regfile.sv
module bulk_cmd_regfile #(
  parameter int NREGS = 48,
  localparam int VW = NREGS * 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          store_en,
  input  logic [7:0]    store_addr,
  input  logic [7:0]    store_data,
  input  logic          commit,
  output logic [VW-1:0] shd_vec,
  output logic [VW-1:0] act_vec
);
  for (genvar i = 0; i < NREGS; i++) begin : g_reg
    logic [7:0] shd_q, act_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        shd_q <= '0;
        act_q <= '0;
      end else begin
        if (store_en && store_addr == 8'(i)) shd_q <= store_data;
        if (commit) act_q <= shd_q;
      end
    end
    assign shd_vec[i*8 +: 8] = shd_q;
    assign act_vec[i*8 +: 8] = act_q;
  end
endmodule

// File: rtl/bulk_cmd_decoder.sv
module bulk_cmd_decoder
  import bulk_cmd_pkg::*;
#(
  parameter int NREGS = 48,
  localparam int VW = NREGS * 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [7:0]    in_data,
  output logic          in_ready,
  output logic          locked,
  output logic [VW-1:0] act_regs,
  output logic [23:0]   base16,
  output logic [23:0]   base8,
  output logic [15:0]   pclk_div,
  output logic          copy_valid,
  output logic [23:0]   copy_src,
  output logic [7:0]    copy_count,
  output logic [23:0]   copy_dst
);
  logic          wr_fire;
  logic [7:0]    wr_addr, wr_data;
  logic          store_en, commit_fire;
  logic [VW-1:0] shd_regs;
  logic [511:0]  act_wide;

  assign in_ready = 1'b1;

  bulk_cmd_parser u_parser (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .wr_fire(wr_fire), .wr_addr(wr_addr), .wr_data(wr_data),
    .copy_valid(copy_valid), .copy_src(copy_src),
    .copy_count(copy_count), .copy_dst(copy_dst)
  );

  bulk_cmd_lockctl #(.NREGS(NREGS)) u_lock (
    .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire), .wr_addr(wr_addr),
    .wr_data(wr_data), .store_en(store_en), .commit_fire(commit_fire),
    .locked(locked)
  );

  bulk_cmd_regfile #(.NREGS(NREGS)) u_regs (
    .clk(clk), .rst_n(rst_n), .store_en(store_en), .store_addr(wr_addr),
    .store_data(wr_data), .commit(commit_fire),
    .shd_vec(shd_regs), .act_vec(act_regs)
  );

  assign act_wide = 512'(act_regs);
  assign base16   = {reg_of(act_wide, B16_HI), reg_of(act_wide, B16_HI + 1),
                     reg_of(act_wide, B16_HI + 2)};
  assign base8    = {reg_of(act_wide, B8_HI), reg_of(act_wide, B8_HI + 1),
                     reg_of(act_wide, B8_HI + 2)};
  assign pclk_div = {reg_of(act_wide, PCLK_LO + 1), reg_of(act_wide, PCLK_LO)};
endmodule

// File: rtl/bulk_cmd_decoder_chk.sv
module bulk_cmd_decoder_chk #(
  parameter int NREGS = 48
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               copy_valid,
  input logic               wr_fire,
  input logic               commit_fire,
  input logic               locked,
  input logic [NREGS*8-1:0] act_regs,
  input logic [NREGS*8-1:0] shd_regs
);
  // R2
  act_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_fire |=> $stable(act_regs));
  // R3
  commit_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_fire |=> act_regs == $past(shd_regs));
  // R6
  copy_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    copy_valid |=> !copy_valid);
  // R11
  copy_needs_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(copy_valid) |-> $past(in_valid));
  // R11
  write_needs_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |-> in_valid);
  // R4
  lock_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(wr_fire));
  // R4
  unlock_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_fire |=> !locked);
endmodule

bind bulk_cmd_decoder bulk_cmd_decoder_chk #(.NREGS(NREGS)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .copy_valid(copy_valid),
  .wr_fire(wr_fire), .commit_fire(commit_fire), .locked(locked),
  .act_regs(act_regs), .shd_regs(shd_regs)
);

// File: tb/bulk_cmd_decoder_test.sv
module bulk_cmd_decoder_test;
  localparam int NREGS = 48;
  localparam int VW = NREGS * 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic in_ready, locked, copy_valid;
  logic [VW-1:0] act_regs;
  logic [23:0] base16, base8, copy_src, copy_dst;
  logic [15:0] pclk_div;
  logic [7:0] copy_count;

  int checks = 0;
  int errors = 0;
  logic [7:0] m_shd [NREGS];
  logic [7:0] m_act [NREGS];
  logic m_lock = 1'b0;
  logic [55:0] exp_q [$];
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bulk_cmd_decoder #(.NREGS(NREGS)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .locked(locked), .act_regs(act_regs),
    .base16(base16), .base8(base8), .pclk_div(pclk_div),
    .copy_valid(copy_valid), .copy_src(copy_src),
    .copy_count(copy_count), .copy_dst(copy_dst)
  );

  task automatic check(input string tag, input logic [511:0] act, input logic [511:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [VW-1:0] model_vec();
    logic [VW-1:0] v;
    for (int i = 0; i < NREGS; i++) v[i*8 +: 8] = m_act[i];
    return v;
  endfunction

  // start and end at a negedge; in_valid stays high
  task automatic send(input logic [7:0] b);
    in_valid = 1'b1;
    in_data  = b;
    @(negedge clk);
  endtask

  task automatic halt();
    in_valid = 1'b0;
  endtask

  task automatic wreg(input logic [7:0] a, input logic [7:0] d);
    send(8'hAF); send(8'h20); send(a); send(d);
    if (a == 8'hFF) begin
      if (d == 8'hFF) begin
        m_lock = 1'b0;
        for (int i = 0; i < NREGS; i++) m_act[i] = m_shd[i];
      end else if (d == 8'h00) m_lock = 1'b1;
    end else if (int'(a) < NREGS) m_shd[a] = d;
  endtask

  task automatic copy_msg(input logic [23:0] s, input logic [7:0] n, input logic [23:0] d);
    exp_q.push_back({s, n, d});
    send(8'hAF); send(8'h6A);
    send(s[23:16]); send(s[15:8]); send(s[7:0]); send(n);
    send(d[23:16]); send(d[15:8]); send(d[7:0]);
  endtask

  task automatic state_chk(input string tag);
    halt();
    check({tag, " act_regs"}, 512'(act_regs), 512'(model_vec()));
    check({tag, " locked"}, 512'(locked), 512'(m_lock));
  endtask

  // monitor: pop expected copy requests as they appear
  always @(negedge clk) begin
    if (rst_n && copy_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R6 unexpected copy actual=%0h expected=none",
                 {copy_src, copy_count, copy_dst});
      end else begin
        logic [55:0] e;
        e = exp_q.pop_front();
        if ({copy_src, copy_count, copy_dst} !== e) begin
          errors++;
          $display("FAIL R6 copy fields actual=%0h expected=%0h",
                   {copy_src, copy_count, copy_dst}, e);
        end
      end
    end
  end

  initial begin
    for (int i = 0; i < NREGS; i++) begin m_shd[i] = 8'h00; m_act[i] = 8'h00; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check("R1 act_regs", 512'(act_regs), 512'(0));
    check("R1 locked", 512'(locked), 512'(0));
    check("R1 copy_valid", 512'(copy_valid), 512'(0));
    check("R11 in_ready", 512'(in_ready), 512'(1));

    // R4 lock, R2 staged writes
    wreg(8'hFF, 8'h00);
    wreg(8'h20, 8'h12); wreg(8'h21, 8'h34); wreg(8'h22, 8'h56);
    state_chk("R2 R4 locked staging");
    wreg(8'hFF, 8'hFF);
    state_chk("R3 unlock commit");
    check("R5 base16", 512'(base16), 512'(24'h123456));

    // R4 other value to lock address ignored
    wreg(8'hFF, 8'h00);
    wreg(8'hFF, 8'h55);
    state_chk("R4 stray lock value");

    // R2 writes without commit; then unlock back to back with a copy
    wreg(8'h26, 8'hAB); wreg(8'h27, 8'hCD); wreg(8'h28, 8'hEF);
    state_chk("R2 no commit yet");
    wreg(8'hFF, 8'hFF);
    copy_msg(24'h010203, 8'h40, 24'hA0B0C0);
    wreg(8'h05, 8'h77);
    state_chk("R3 commit then copy");
    check("R5 base8", 512'(base8), 512'(24'hABCDEF));

    // R7 header pads
    send(8'hAF); send(8'hAF);
    wreg(8'h1B, 8'h34);
    send(8'hAF);
    halt();
    @(negedge clk);
    // R8 unknown command skips until header
    send(8'hAF); send(8'h11); send(8'h20); send(8'h05); send(8'h06);
    wreg(8'h1C, 8'h12);
    wreg(8'hFF, 8'hFF);
    state_chk("R7 R8 pad and skip");
    check("R5 pclk_div", 512'(pclk_div), 512'(16'h1234));

    // R9 junk between messages
    send(8'h20); send(8'h05); send(8'h99);
    wreg(8'hFF, 8'hFF);
    state_chk("R9 idle junk");

    // R10 out-of-range address
    wreg(8'h40, 8'h5A); wreg(8'hFE, 8'h5A);
    wreg(8'hFF, 8'hFF);
    state_chk("R10 out of range");

    // R11 bytes without valid are not taken
    in_valid = 1'b0; in_data = 8'hAF;
    repeat (3) @(negedge clk);
    send(8'h20); send(8'h05); send(8'h99);
    wreg(8'hFF, 8'hFF);
    state_chk("R11 valid low ignored");

    copy_msg(24'hFFFFFF, 8'h01, 24'h000000);
    halt();
    repeat (3) @(negedge clk);
    check("R6 copy queue drained", 512'(exp_q.size()), 512'(0));
    done = 1'b1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule